// File: doc/BRIEF.md
# Padded Frame Transmitter

This block reads 16-bit trigger words from a send FIFO and presents them to a serial link as fixed-length frames. The link takes one word per cycle with a source-ready / destination-ready handshake. The first word of each frame carries a start-of-frame mark and the last word carries an end-of-frame mark. After reset the block sends nothing until the FIFO holds a start reserve of words. That reserve covers later link stalls, so the receiving side never runs dry.

While streaming, the block must absorb two kinds of interruption. The first is the link's periodic clock-compensation interval. A request input asks for it, and the block grants it between word transfers. For a fixed number of cycles no word is offered. Sending then resumes with the next word of the same frame. The second is a send FIFO that runs empty part-way through a frame. The block stops offering words and keeps its frame position until data returns. Frames follow each other with no idle cycle, so framing adds no overhead to throughput.

The output word, its marks and the ready flag sit in one register stage. A word that is offered but not yet accepted stays unchanged until the link takes it.

Top module: `padded_frame_tx`

## Requirements
- R1: After a synchronous reset, `lnk_src_rdy`, `lnk_sof`, `lnk_eof`, `lnk_comp_busy` and `fifo_rd` are all low, and the block again waits for the start reserve.
- R2: Until `fifo_level` has reached START_RESERVE (11) at least once since reset, no word is read or offered. `lnk_src_rdy` rises two cycles after the level first reaches the reserve.
- R3: Every word read from the FIFO is delivered exactly once, in FIFO order. A word is delivered in a cycle where `lnk_src_rdy` and `lnk_dst_rdy` are both high.
- R4: Counting delivered words from reset, word k carries `lnk_sof` when k mod 64 is 0 and `lnk_eof` when k mod 64 is 63. Stalls never shift these positions.
- R5: While `lnk_src_rdy` is high and `lnk_dst_rdy` is low, `lnk_data`, `lnk_sof`, `lnk_eof` and `lnk_src_rdy` hold their values into the next cycle.
- R6: `fifo_rd` is never high while `fifo_empty` is high. If the FIFO runs dry in mid-frame, the block stops offering words and resumes at the next frame position when words return, even when fewer than the reserve arrive.
- R7: A request on `comp_req` leads to exactly 6 consecutive cycles with `lnk_comp_busy` high and `lnk_src_rdy` low. The interval begins only when no word is left unaccepted, and a request raised before the reserve is met waits until streaming starts.
- R8: A request raised during an interval, or in the cycle an interval is granted, is merged into that interval and causes no further interval.
- R9: With `lnk_dst_rdy` held high, no compensation request and the FIFO never empty, one word is delivered every cycle, across frame boundaries included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_rdata | input | DATA_W (16) | Head word of the send FIFO (show-ahead) |
| fifo_empty | input | 1 | Send FIFO holds no word |
| fifo_level | input | LEVEL_W (8) | Number of words held in the send FIFO |
| fifo_rd | output | 1 | Pop the head word at this clock edge |
| comp_req | input | 1 | Request for a clock-compensation interval |
| lnk_data | output | DATA_W (16) | Word offered to the link |
| lnk_sof | output | 1 | Offered word is the first of a frame |
| lnk_eof | output | 1 | Offered word is the last of a frame |
| lnk_src_rdy | output | 1 | A word is offered |
| lnk_dst_rdy | input | 1 | Link accepts the offered word |
| lnk_comp_busy | output | 1 | Compensation interval in progress |

## Verification
The hardest case to reach from the ports is a compensation interval that meets an unaccepted word, a frame boundary and a second request in the same few cycles. To get there, the stimulus streams several frames with destination-ready toggling at random, raises requests on a short period that is prime to the frame length, and fires one extra request deliberately inside a running interval. FIFO starvation is forced by letting the bench's FIFO drain in mid-frame and then refilling it with fewer words than the reserve. The scoreboard then shows that the frame marks still land on the right words.

// File: rtl/pft_pkg.sv
`timescale 1ns/1ps
package pft_pkg;

  typedef enum logic [1:0] {
    PH_FILL = 2'd0,
    PH_RUN  = 2'd1,
    PH_COMP = 2'd2
  } pft_phase_e;

  // True once the FIFO holds enough words to start streaming.
  function automatic logic reserve_met(input int unsigned level, input int unsigned need);
    return level >= need;
  endfunction

  // Frame position that follows pos for a frame of flen words.
  function automatic int unsigned pos_after(input int unsigned pos, input int unsigned flen);
    return (pos + 1 >= flen) ? 0 : pos + 1;
  endfunction

  // Width of a counter that must hold the values 0..n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pft_reserve_gate.sv
`timescale 1ns/1ps
module pft_reserve_gate #(
  parameter int unsigned LEVEL_W = 8,
  parameter int unsigned NEED    = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] fifo_level,
  output logic               armed
);
  import pft_pkg::*;

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= armed_q | reserve_met(32'(fifo_level), NEED);
  end

  assign armed = armed_q;
endmodule

// File: rtl/pft_comp_timer.sv
`timescale 1ns/1ps
module pft_comp_timer #(
  parameter int unsigned COMP_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic comp_req,
  input  logic grant,
  output logic pend,
  output logic busy
);
  import pft_pkg::*;

  localparam int unsigned CW = cnt_width(COMP_LEN);
  localparam logic [CW-1:0] LAST = CW'(COMP_LEN - 1);

  logic          pend_q, busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      // A new request is merged into one being granted or served.
      if (grant)       pend_q <= 1'b0;
      else if (!busy_q) pend_q <= pend_q | comp_req;

      if (grant) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) busy_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pend = pend_q;
  assign busy = busy_q;
endmodule

// File: rtl/pft_frame_pos.sv
`timescale 1ns/1ps
module pft_frame_pos #(
  parameter int unsigned FRAME_LEN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic first,
  output logic last
);
  import pft_pkg::*;

  localparam int unsigned PW = cnt_width(FRAME_LEN);
  localparam bit POW2 = (FRAME_LEN > 1) && ((FRAME_LEN & (FRAME_LEN - 1)) == 0);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_n;

  generate
    if (POW2) begin : g_wrap_free
      // Power-of-two length: the counter wraps by itself.
      assign pos_n = pos_q + 1'b1;
    end else begin : g_wrap_cmp
      assign pos_n = PW'(pos_after(32'(pos_q), FRAME_LEN));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      pos_q <= '0;
    else if (adv) pos_q <= pos_n;
  end

  assign first = (pos_q == '0);
  assign last  = (pos_q == PW'(FRAME_LEN - 1));
endmodule

// File: rtl/padded_frame_tx.sv
`timescale 1ns/1ps
module padded_frame_tx #(
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned LEVEL_W       = 8,
  parameter int unsigned FRAME_LEN     = 64,
  parameter int unsigned START_RESERVE = 11,
  parameter int unsigned COMP_LEN      = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  fifo_rdata,
  input  logic               fifo_empty,
  input  logic [LEVEL_W-1:0] fifo_level,
  output logic               fifo_rd,
  input  logic               comp_req,
  output logic [DATA_W-1:0]  lnk_data,
  output logic               lnk_sof,
  output logic               lnk_eof,
  output logic               lnk_src_rdy,
  input  logic               lnk_dst_rdy,
  output logic               lnk_comp_busy
);
  import pft_pkg::*;

  // Named internal events, also seen by the bound checker.
  logic       armed;
  logic       pend;
  logic       busy;
  logic       xfer_w;
  logic       slot_free_w;
  logic       grant_w;
  logic       load_w;
  logic       first_w, last_w;
  pft_phase_e phase;

  // Output register stage.
  logic [DATA_W-1:0] odata_q;
  logic              ovalid_q, osof_q, oeof_q;

  pft_reserve_gate #(.LEVEL_W(LEVEL_W), .NEED(START_RESERVE)) u_gate (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .armed(armed)
  );

  pft_comp_timer #(.COMP_LEN(COMP_LEN)) u_comp (
    .clk(clk), .rst(rst), .comp_req(comp_req), .grant(grant_w),
    .pend(pend), .busy(busy)
  );

  pft_frame_pos #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk(clk), .rst(rst), .adv(load_w), .first(first_w), .last(last_w)
  );

  always_comb begin
    if (!armed)    phase = PH_FILL;
    else if (busy) phase = PH_COMP;
    else           phase = PH_RUN;
  end

  assign xfer_w      = ovalid_q & lnk_dst_rdy;
  assign slot_free_w = ~ovalid_q | xfer_w;
  assign grant_w     = (phase == PH_RUN) & slot_free_w & pend;
  assign load_w      = (phase == PH_RUN) & slot_free_w & ~pend & ~fifo_empty & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovalid_q <= 1'b0;
      osof_q   <= 1'b0;
      oeof_q   <= 1'b0;
      odata_q  <= '0;
    end else if (slot_free_w) begin
      ovalid_q <= load_w;
      osof_q   <= load_w & first_w;
      oeof_q   <= load_w & last_w;
      if (load_w) odata_q <= fifo_rdata;
    end
  end

  assign fifo_rd       = load_w;
  assign lnk_data      = odata_q;
  assign lnk_sof       = osof_q;
  assign lnk_eof       = oeof_q;
  assign lnk_src_rdy   = ovalid_q;
  assign lnk_comp_busy = busy;
endmodule

// File: rtl/pft_checker.sv
`timescale 1ns/1ps
module pft_checker #(
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned LEVEL_W       = 8,
  parameter int unsigned FRAME_LEN     = 64,
  parameter int unsigned START_RESERVE = 11,
  parameter int unsigned COMP_LEN      = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               fifo_empty,
  input logic               fifo_rd,
  input logic [LEVEL_W-1:0] fifo_level,
  input logic [DATA_W-1:0]  lnk_data,
  input logic               lnk_sof,
  input logic               lnk_eof,
  input logic               lnk_src_rdy,
  input logic               lnk_dst_rdy,
  input logic               lnk_comp_busy,
  input logic               armed,
  input logic               pend,
  input logic               xfer
);
  int unsigned xcnt;
  int unsigned blen;

  always_ff @(posedge clk) begin
    if (rst) begin
      xcnt <= 0;
      blen <= 0;
    end else begin
      if (xfer) xcnt <= (xcnt + 1 >= FRAME_LEN) ? 0 : xcnt + 1;
      blen <= lnk_comp_busy ? blen + 1 : 0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !lnk_src_rdy && !lnk_sof && !lnk_eof && !lnk_comp_busy && !fifo_rd);

  assert_hold_until_reserve_R2: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !fifo_rd && !lnk_src_rdy);

  assert_arm_on_level_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(fifo_level) >= LEVEL_W'(START_RESERVE));

  assert_frame_marks_R4: assert property (@(posedge clk) disable iff (rst)
    xfer |-> (lnk_sof == (xcnt == 0)) && (lnk_eof == (xcnt == FRAME_LEN - 1)));

  assert_offer_held_R5: assert property (@(posedge clk) disable iff (rst)
    lnk_src_rdy && !lnk_dst_rdy |=> lnk_src_rdy && $stable(lnk_data)
                                    && $stable(lnk_sof) && $stable(lnk_eof));

  assert_no_read_empty_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !fifo_empty);

  assert_starve_idle_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_empty && !lnk_src_rdy |=> !lnk_src_rdy);

  assert_quiet_in_comp_R7: assert property (@(posedge clk) disable iff (rst)
    lnk_comp_busy |-> !lnk_src_rdy && !fifo_rd);

  assert_comp_from_request_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lnk_comp_busy) |-> $past(pend));

  assert_comp_length_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(lnk_comp_busy) && !$past(rst) |-> blen == COMP_LEN);
endmodule

bind padded_frame_tx pft_checker #(
  .DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .FRAME_LEN(FRAME_LEN),
  .START_RESERVE(START_RESERVE), .COMP_LEN(COMP_LEN)
) u_pft_checker (
  .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
  .fifo_level(fifo_level), .lnk_data(lnk_data), .lnk_sof(lnk_sof),
  .lnk_eof(lnk_eof), .lnk_src_rdy(lnk_src_rdy), .lnk_dst_rdy(lnk_dst_rdy),
  .lnk_comp_busy(lnk_comp_busy), .armed(armed), .pend(pend), .xfer(xfer_w)
);

// File: tb/padded_frame_tx_bench.sv
`timescale 1ns/1ps
module padded_frame_tx_bench;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int FLEN = 64;
  localparam int PAD = 11;
  localparam int CLEN = 6;
  localparam int COMP_PERIOD = 97;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic [DW-1:0] fifo_rdata = '0;
  logic          fifo_empty = 1'b1;
  logic [LW-1:0] fifo_level = '0;
  logic          fifo_rd;
  logic          comp_req = 1'b0;
  logic [DW-1:0] lnk_data;
  logic          lnk_sof, lnk_eof, lnk_src_rdy, lnk_comp_busy;
  logic          lnk_dst_rdy = 1'b1;

  padded_frame_tx #(.DATA_W(DW), .LEVEL_W(LW), .FRAME_LEN(FLEN),
                    .START_RESERVE(PAD), .COMP_LEN(CLEN)) u_padded_frame_tx (
    .clk(clk), .rst(rst), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .fifo_level(fifo_level), .fifo_rd(fifo_rd), .comp_req(comp_req),
    .lnk_data(lnk_data), .lnk_sof(lnk_sof), .lnk_eof(lnk_eof),
    .lnk_src_rdy(lnk_src_rdy), .lnk_dst_rdy(lnk_dst_rdy),
    .lnk_comp_busy(lnk_comp_busy)
  );

  typedef struct packed { logic [DW-1:0] d; logic s; logic e; } exp_t;
  logic [DW-1:0] fq[$];
  exp_t          eq[$];
  int pushed = 0;
  int checks = 0, fails = 0;
  int xfers = 0, comp_runs = 0, blen = 0;
  bit rd_s = 0, any_act = 0, prev_busy = 0, prev_hold = 0, done = 0;
  exp_t prev_w;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    fifo_level = (fq.size() > 255) ? 8'd255 : LW'(fq.size());
    fifo_rdata = fifo_empty ? '0 : fq[0];
  endtask

  // Driver: each word goes into the FIFO model and its expectation into the scoreboard.
  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] w;
      w = DW'($urandom);
      fq.push_back(w);
      eq.push_back('{d: w, s: (pushed % FLEN) == 0, e: (pushed % FLEN) == FLEN - 1});
      pushed++;
    end
    refresh();
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_comp();
    comp_req = 1'b1;
    @(negedge clk);
    comp_req = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 5000 && eq.size() != 0; i++) @(negedge clk);
    chk(eq.size() == 0, req, "undelivered words", eq.size(), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fq.delete();
    eq.delete();
    pushed = 0;
    refresh();
    cycles(3);
    rst = 1'b0;
  endtask

  // FIFO model pops after the edge on a read sampled before it.
  always @(posedge clk) begin
    #1;
    if (rd_s && fq.size() != 0) void'(fq.pop_front());
    refresh();
  end

  // Monitor / scoreboard.
  always @(negedge clk) begin
    #1;
    rd_s = fifo_rd && !rst;
    if (rst) begin
      prev_hold = 0;
      prev_busy = 0;
      blen = 0;
    end else begin
      if (lnk_src_rdy || fifo_rd) any_act = 1;
      if (fifo_rd) chk(!fifo_empty, "R6", "read while empty", fifo_empty, 0);
      if (prev_hold)
        chk(lnk_src_rdy && lnk_data == prev_w.d && lnk_sof == prev_w.s && lnk_eof == prev_w.e,
            "R5", "held word changed", lnk_data, prev_w.d);
      if (lnk_src_rdy && lnk_dst_rdy) begin
        if (eq.size() == 0) chk(0, "R3", "unexpected word", lnk_data, 0);
        else begin
          exp_t e;
          e = eq.pop_front();
          chk(lnk_data == e.d, "R3", "word order", lnk_data, e.d);
          chk({lnk_sof, lnk_eof} == {e.s, e.e}, "R4", "frame marks",
              {lnk_sof, lnk_eof}, {e.s, e.e});
        end
        xfers++;
      end
      if (lnk_comp_busy) begin
        blen++;
        if (lnk_src_rdy) chk(0, "R7", "word offered during interval", 1, 0);
      end else if (prev_busy) begin
        chk(blen == CLEN, "R7", "interval length", blen, CLEN);
        comp_runs++;
        blen = 0;
      end
      prev_busy = lnk_comp_busy;
      prev_hold = lnk_src_rdy && !lnk_dst_rdy;
      prev_w    = '{d: lnk_data, s: lnk_sof, e: lnk_eof};
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    int x0, r0;
    refresh();
    do_reset();
    @(negedge clk);
    // R1: idle outputs after reset
    chk(!lnk_src_rdy && !lnk_sof && !lnk_eof && !lnk_comp_busy && !fifo_rd,
        "R1", "outputs after reset", {lnk_src_rdy, lnk_sof, lnk_eof, lnk_comp_busy, fifo_rd}, 0);

    // R2: below reserve nothing moves; a request waits for streaming (R7)
    push_words(PAD - 1);
    pulse_comp();
    any_act = 0;
    cycles(20);
    chk(!any_act, "R2", "activity below reserve", any_act, 0);
    chk(!lnk_comp_busy && comp_runs == 0, "R7", "interval before start", comp_runs, 0);
    push_words(1);
    @(negedge clk);
    chk(!lnk_src_rdy, "R2", "offer one cycle after reserve", lnk_src_rdy, 0);
    @(negedge clk);
    chk(lnk_src_rdy || lnk_comp_busy, "R2", "start after reserve", lnk_src_rdy, 1);
    wait_drain("R3");
    chk(comp_runs == 1, "R7", "pending request served after start", comp_runs, 1);

    // R9: full rate across frame boundaries
    push_words(220);
    cycles(3);
    x0 = xfers;
    cycles(150);
    chk(xfers - x0 == 150, "R9", "words in 150 cycles", xfers - x0, 150);

    // R6: run dry mid-frame, then refill below reserve
    wait_drain("R3");
    cycles(5);
    chk(!lnk_src_rdy && !fifo_rd, "R6", "idle while starved", lnk_src_rdy, 0);
    chk((pushed % FLEN) != 0, "R6", "starved mid-frame", pushed % FLEN, 1);
    push_words(5);
    wait_drain("R6");

    // R5: random backpressure
    push_words(150);
    for (int i = 0; i < 300; i++) begin
      lnk_dst_rdy = ($urandom % 3) != 0;
      @(negedge clk);
    end
    lnk_dst_rdy = 1'b1;
    wait_drain("R5");

    // R7: single request mid-stream
    push_words(200);
    cycles(30);
    r0 = comp_runs;
    pulse_comp();
    cycles(20);
    chk(comp_runs - r0 == 1, "R7", "one interval per request", comp_runs - r0, 1);

    // R8: extra request while an interval runs
    r0 = comp_runs;
    comp_req = 1'b1;
    @(negedge clk);
    comp_req = 1'b0;
    for (int i = 0; i < 10 && !lnk_comp_busy; i++) @(negedge clk);
    pulse_comp();
    cycles(30);
    chk(comp_runs - r0 == 1, "R8", "merged request", comp_runs - r0, 1);
    wait_drain("R7");

    // R7/R4: periodic requests with backpressure over several frames
    push_words(250);
    for (int i = 0; i < 700; i++) begin
      lnk_dst_rdy = ($urandom % 4) != 0;
      comp_req = (i % COMP_PERIOD) == 5;
      if (i % 150 == 149) push_words(40);
      @(negedge clk);
    end
    comp_req = 1'b0;
    lnk_dst_rdy = 1'b1;
    wait_drain("R4");

    // R1: reset in mid-stream re-arms the reserve
    push_words(60);
    cycles(20);
    do_reset();
    @(negedge clk);
    chk(!lnk_src_rdy && !lnk_sof && !lnk_eof && !lnk_comp_busy && !fifo_rd,
        "R1", "outputs after mid-run reset", lnk_src_rdy, 0);
    push_words(5);
    any_act = 0;
    cycles(20);
    chk(!any_act, "R2", "reserve needed again after reset", any_act, 0);
    push_words(70);
    wait_drain("R4");

    done = 1;
    finish_run();
  end
endmodule